// File: doc/BRIEF.md
# Nonvolatile Store Program Sequencer

This block decides whether a setting that the serial front end has just received is committed to the nonvolatile store. Each time the front end finishes a frame it raises a one-cycle strobe together with the target channel address and the 8-bit value. The block holds that value as pending. It then watches the program request line during a short acceptance window. If the request shows up in time and the supply is healthy, the block runs a timed erase/write interval and finishes it with a single write pulse to the store.

While the interval runs, the ready/busy line is driven low. A block signal also tells the serial front end to ignore incoming data and leave its output undriven. The interval is counted in clock cycles, and the clock must keep running the whole time. The cycle count is a parameter chosen to cover the minimum program time of the cells. The sequencer gives up without writing in three cases: the request comes too late, the supply monitor reports a low supply, or the request is released before the count completes.

Top module: `nvs_prog_seq`

## Requirements
- R1: While reset is held and right after it is released, rdyBsy is 1, storeWe is 0 and serialBlock is 0.
- R2: A frame strobe in cycle c0 is accepted if progReq and supplyOk are both 1 in cycle c0 or in cycle c0+1. rdyBsy goes to 0 in the cycle after the acceptance cycle.
- R3: If progReq is first 1 two or more cycles after the frame strobe cycle, the pending value is discarded. No busy period starts and storeWe stays 0.
- R4: Once a request is accepted in cycle a, and progReq and supplyOk stay 1 through cycles a+1..a+BUSY_CYC, rdyBsy is 0 in cycles a+1..a+BUSY_CYC+1. storeWe is 1 only in cycle a+BUSY_CYC+1, and rdyBsy is 1 again in cycle a+BUSY_CYC+2.
- R5: storeWe is a single-cycle pulse. While it is 1, storeAddr and storeData carry the address and value of the frame that was accepted.
- R6: If supplyOk is 0 in the cycle where the request would be accepted, rdyBsy stays 1 and no write takes place.
- R7: If supplyOk drops to 0 during the busy period, rdyBsy returns to 1 in the next cycle and no write takes place.
- R8: If progReq drops to 0 during the busy period before the count completes, rdyBsy returns to 1 in the next cycle and no write takes place.
- R9: serialBlock is 1 exactly in the cycles where rdyBsy is 0.
- R10: A frame strobe that arrives during the busy period is ignored. The write keeps its original timing and carries the originally accepted address and value.
- R11: progReq held high with no preceding frame strobe starts no busy period and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; keeps running through the busy period |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: a complete frame was received |
| frameAddr | input | ADDR_W | Channel address of the received frame |
| frameData | input | DATA_W | Setting value of the received frame |
| progReq | input | 1 | Program request level |
| supplyOk | input | 1 | Supply monitor: 1 when the supply is high enough to program |
| rdyBsy | output | 1 | 1 when ready, 0 during erase/write |
| storeWe | output | 1 | Single-cycle write enable to the store |
| storeAddr | output | ADDR_W | Address for the store write |
| storeData | output | DATA_W | Value for the store write |
| serialBlock | output | 1 | Tells the serial front end to ignore input and leave its output undriven |

## Verification
The frame strobe is cycle c0, and a request is accepted in cycle s, which is c0 or c0+1. rdyBsy and serialBlock therefore change in cycle s+1, and the write pulse falls in cycle s+BUSY_CYC+1. An abort caused by progReq or supplyOk in cycle q shows up at the outputs in cycle q+1. The bench drives inputs on the falling edge. At each falling edge it first compares the outputs against values it computed for that cycle from the request start, the request length and the supply-drop cycle, and only then applies that cycle's inputs. The sweep covers every request start from c0 to c0+3, every request length from zero to past the full count, and supply drops both at acceptance and in the middle of the busy period.

// File: rtl/nvs_seq_pkg.sv
package nvs_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_BUSY,
    ST_WRITE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic cntClr;
    logic cntInc;
  } seqStrb_t;
endpackage

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl
  import nvs_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameDone,
  input  logic     progReq,
  input  logic     supplyOk,
  input  logic     cntLast,
  output seqStrb_t strb,
  output logic     busyPhase,
  output logic     writePhase
);
  seqState_t state, stateNxt;
  logic      goAhead;

  assign goAhead = progReq && supplyOk;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (frameDone) begin
          strb.capture = 1'b1;
          if (goAhead) begin
            stateNxt    = ST_BUSY;
            strb.cntClr = 1'b1;
          end else if (progReq) begin
            stateNxt = ST_IDLE;
          end else begin
            stateNxt = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (goAhead) begin
          stateNxt    = ST_BUSY;
          strb.cntClr = 1'b1;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_BUSY: begin
        if (!goAhead)     stateNxt = ST_IDLE;
        else if (cntLast) stateNxt = ST_WRITE;
        else              strb.cntInc = 1'b1;
      end
      ST_WRITE: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busyPhase  = (state == ST_BUSY) || (state == ST_WRITE);
  assign writePhase = (state == ST_WRITE);
endmodule

// File: rtl/nvs_seq_dpath.sv
module nvs_seq_dpath
  import nvs_seq_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [DATA_W-1:0] frameData,
  output logic              cntLast,
  output logic [ADDR_W-1:0] pendAddr,
  output logic [DATA_W-1:0] pendData
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BUSY_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
    end else if (strb.capture) begin
      pendAddr <= frameAddr;
      pendData <= frameData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + CNT_W'(1);
  end

  assign cntLast = (cnt == CNT_END);
endmodule

// File: rtl/nvs_prog_seq.sv
module nvs_prog_seq
  import nvs_seq_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [DATA_W-1:0] frameData,
  input  logic              progReq,
  input  logic              supplyOk,
  output logic              rdyBsy,
  output logic              storeWe,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  output logic              serialBlock
);
  seqStrb_t strb;
  logic     cntLast;
  logic     busyPhase;
  logic     writePhase;

  nvs_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameDone  (frameDone),
    .progReq    (progReq),
    .supplyOk   (supplyOk),
    .cntLast    (cntLast),
    .strb       (strb),
    .busyPhase  (busyPhase),
    .writePhase (writePhase)
  );

  nvs_seq_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUSY_CYC (BUSY_CYC)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frameAddr (frameAddr),
    .frameData (frameData),
    .cntLast   (cntLast),
    .pendAddr  (storeAddr),
    .pendData  (storeData)
  );

  assign rdyBsy      = !busyPhase;
  assign serialBlock = busyPhase;
  assign storeWe     = writePhase;
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              progReq,
  input logic              supplyOk,
  input logic              rdyBsy,
  input logic              storeWe,
  input logic              serialBlock,
  input logic [DATA_W-1:0] storeData
);
  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBsy) |-> $past(progReq && supplyOk));

  // R4
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeWe |-> (!rdyBsy && $past(progReq && supplyOk)));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeWe |=> (!storeWe && rdyBsy));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBsy && $past(!rdyBsy)) |-> $stable(storeData));

  // R7
  low_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> rdyBsy);

  // R8
  prog_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBsy && !storeWe && !progReq) |=> (rdyBsy && !storeWe));

  // R9
  block_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    serialBlock == !rdyBsy);
endmodule

bind nvs_prog_seq nvs_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .progReq     (progReq),
  .supplyOk    (supplyOk),
  .rdyBsy      (rdyBsy),
  .storeWe     (storeWe),
  .serialBlock (serialBlock),
  .storeData   (storeData)
);

// File: tb/sim_nvs_prog_seq.sv
module sim_nvs_prog_seq;
  localparam int CLK_PER = 10;
  localparam int NBUSY   = 6;
  localparam int AW      = 1;
  localparam int DW      = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          frameDone;
  logic [AW-1:0] frameAddr;
  logic [DW-1:0] frameData;
  logic          progReq;
  logic          supplyOk;
  logic          rdyBsy;
  logic          storeWe;
  logic [AW-1:0] storeAddr;
  logic [DW-1:0] storeData;
  logic          serialBlock;

  int nChk = 0;
  int nBad = 0;

  nvs_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYC(NBUSY)) u0 (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameAddr(frameAddr),
    .frameData(frameData), .progReq(progReq), .supplyOk(supplyOk),
    .rdyBsy(rdyBsy), .storeWe(storeWe), .storeAddr(storeAddr),
    .storeData(storeData), .serialBlock(serialBlock)
  );

  always #(CLK_PER / 2) clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit progAt(int c, int s, int len);
    return (c >= s) && (c < s + len);
  endfunction

  function automatic bit supAt(int c, int dropAt, int dropLen);
    return !((c >= dropAt) && (c < dropAt + dropLen));
  endfunction

  task automatic goIdle();
    @(negedge clk);
    frameDone = 1'b0;
    progReq   = 1'b0;
    supplyOk  = 1'b1;
    frameAddr = '0;
    frameData = '0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(rdyBsy == 1'b1, "R8", "idle rdyBsy", rdyBsy, 1);
    end
  endtask

  // Cycle 0 carries the frame strobe; request is high for len cycles from s.
  task automatic runCase(int s, int len, int dropAt, int dropLen, int extraAt,
                         logic [AW-1:0] a, logic [DW-1:0] d,
                         logic [AW-1:0] xa, logic [DW-1:0] xd, string tagOv);
    bit    acc;
    bit    okAll;
    int    q;
    int    endBusy;
    bit    expBusy;
    bit    expWe;
    string tag;
    acc     = (s <= 1) && progAt(s, s, len) && supAt(s, dropAt, dropLen);
    q       = -1;
    endBusy = -1;
    okAll   = 1'b0;
    if (acc) begin
      for (int c = s + 1; c <= s + NBUSY; c++) begin
        if (q < 0 && (!progAt(c, s, len) || !supAt(c, dropAt, dropLen))) q = c;
      end
      okAll   = (q < 0);
      endBusy = okAll ? s + NBUSY + 1 : q;
    end
    if (!acc) begin
      if (len == 0)                       tag = "R11";
      else if (s >= 2)                    tag = "R3";
      else                                tag = "R6";
    end else if (okAll)                   tag = "R2";
    else if (!supAt(q, dropAt, dropLen))  tag = "R7";
    else                                  tag = "R8";
    if (tagOv != "") tag = tagOv;

    for (int c = 0; c <= NBUSY + 5; c++) begin
      @(negedge clk);
      expBusy = acc && (c >= s + 1) && (c <= endBusy);
      expWe   = okAll && (c == s + NBUSY + 1);
      chk(rdyBsy == !expBusy, tag, "rdyBsy", rdyBsy, !expBusy);
      chk(storeWe == expWe, (tagOv != "") ? tagOv : "R4", "storeWe", storeWe, expWe);
      chk(serialBlock == expBusy, "R9", "serialBlock", serialBlock, expBusy);
      if (expWe) begin
        chk(storeAddr == a, (tagOv != "") ? tagOv : "R5", "storeAddr", storeAddr, a);
        chk(storeData == d, (tagOv != "") ? tagOv : "R5", "storeData", storeData, d);
      end
      frameDone = (c == 0) || (c == extraAt);
      frameAddr = (c == 0) ? a : xa;
      frameData = (c == 0) ? d : xd;
      progReq   = progAt(c, s, len);
      supplyOk  = supAt(c, dropAt, dropLen);
    end
    goIdle();
  endtask

  initial begin
    #(CLK_PER * 200000);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    frameDone = 1'b0;
    frameAddr = '0;
    frameData = '0;
    progReq   = 1'b1;
    supplyOk  = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdyBsy == 1'b1, "R1", "reset rdyBsy", rdyBsy, 1);
    chk(storeWe == 1'b0, "R1", "reset storeWe", storeWe, 0);
    chk(serialBlock == 1'b0, "R1", "reset serialBlock", serialBlock, 0);
    progReq = 1'b0;
    rstN    = 1'b1;
    @(negedge clk);
    chk(rdyBsy == 1'b1, "R1", "post-reset rdyBsy", rdyBsy, 1);
    chk(storeWe == 1'b0, "R1", "post-reset storeWe", storeWe, 0);

    // Request without any frame (R11)
    for (int c = 0; c < NBUSY + 4; c++) begin
      progReq = 1'b1;
      @(negedge clk);
      chk(rdyBsy == 1'b1 && storeWe == 1'b0, "R11", "no-frame request",
          {rdyBsy, storeWe}, 2);
    end
    goIdle();

    // Sweep: request start, request length, supply-drop variant
    for (int s = 0; s < 4; s++) begin
      for (int len = 0; len <= NBUSY + 2; len++) begin
        for (int m = 0; m < 3; m++) begin
          runCase(s, len, (m == 0) ? 1000 : (m == 1) ? s : s + 3, 1, -1,
                  AW'((s + len + m) % 2), DW'((s * 53 + len * 17 + m * 91 + 7) % 256),
                  '0, '0, "");
        end
      end
    end

    // Frame strobe during busy is ignored (R10)
    runCase(0, NBUSY + 3, 1000, 0, 3, 1'b1, 8'hA5, 1'b0, 8'h3C, "R10");
    runCase(1, NBUSY + 3, 1000, 0, 4, 1'b0, 8'h5A, 1'b1, 8'hC3, "R10");

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule